// File: doc/BRIEF.md
# Memory Operand Addressing-Mode Decoder

This block turns a 3-bit addressing-kind code and the one or two operand bytes that follow it into a typed memory operand. The result is one of four forms:

- a 16-bit absolute address;
- an indirect register index;
- an indirect register index that is further displaced by the C register;
- a signed offset relative to register R0.

An instruction fetcher presents the kind with a `start` strobe. It reads back at once how many operand bytes the kind consumes. It then feeds those bytes one per `byte_valid` cycle, low byte first. The decoder answers with a one-cycle `done` strobe and the operand fields.

Single-byte kinds place the byte in one of three pages:

- page zero;
- the page at 0x0100;
- the high page at 0xFE00.

One single-byte kind instead uses bit 7 and bit 0 of the byte to pick among the indirect and R0-relative forms. Kind codes that name no addressing mode are refused with a one-cycle `err` strobe. The block never reads register-pair contents and never performs the memory access itself. For an indirect form it only reports the even address of the byte pair that holds the pointer.

Top module: `mem_operand_decoder`

## Requirements
- R1: After reset, `done`, `err` and `busy` are low and every operand output is zero.
- R2: `need_cnt` is 1 for kinds 2, 3, 4 and 5, 2 for kind 6, and 0 for kinds 0, 1 and 7. While idle it follows the `kind` input combinationally. While busy it reflects the accepted kind and ignores the `kind` input.
- R3: A `start` with kind 0, 1 or 7 while idle makes `err` high for exactly the next cycle. `busy` and `done` stay low, and the block stays idle.
- R4: Kind 2 with byte bit 7 = 0 and bit 0 = 0 gives `op_kind` = 1 (indirect), `op_reg` = byte bits 6..1, and `op_ptr` = 2 × `op_reg` (the first of the pair 2n, 2n+1).
- R5: Kind 2 with byte bit 7 = 0 and bit 0 = 1 gives `op_kind` = 2 (indirect plus C), with `op_reg` and `op_ptr` formed as in R4.
- R6: Kind 2 with byte bit 7 = 1 gives `op_kind` = 3 (R0-relative), and `op_off` equals byte bits 6..0 sign-extended from bit 6 to 8 bits.
- R7: Kinds 3, 4 and 5 give `op_kind` = 0 (absolute), with `op_addr` = 0xFE00 + byte, 0x0000 + byte and 0x0100 + byte respectively.
- R8: Kind 6 takes two bytes, the first being the low byte, and gives `op_kind` = 0 with `op_addr` = {second, first}.
- R9: `done` is high for exactly the one cycle after the edge that accepts the final operand byte, and `busy` falls on that same edge. Fields not used by the result form read zero.
- R10: `byte_valid` while idle is ignored, and `start` while busy is ignored. Neither changes the decoded result, the byte count or the error strobe.
- R11: A `start` presented in the cycle where `done` is high is accepted, so operands can be decoded back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Present a new addressing kind |
| kind | input | 3 | Addressing-kind code |
| byte_valid | input | 1 | Operand byte present |
| byte_in | input | 8 | Operand byte |
| need_cnt | output | 2 | Operand bytes required by the kind (0 = illegal) |
| busy | output | 1 | Collecting operand bytes |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | One-cycle illegal-kind strobe |
| op_kind | output | 2 | 0 absolute, 1 indirect, 2 indirect plus C, 3 R0-relative |
| op_addr | output | 16 | Absolute address |
| op_reg | output | 6 | Indirect register index |
| op_ptr | output | 8 | Memory address of the indirect register's low byte |
| op_off | output | 8 | Signed R0 offset |

## Verification
Completion of one operand and acceptance of the next kind can fall in the same cycle. The bench provokes this by raising `start` with a new kind in exactly the cycle where `done` is high. It judges the overlap on two counts. First, `done` must drop on the following cycle while `busy` rises. Second, the second operand must decode to its own arithmetically computed value, with the previous result left out of it. Every kind is swept against all 256 byte values, and every byte count is checked against the kind before the first byte is given.

// File: rtl/mem_operand_decoder.sv
module mem_operand_decoder #(
  parameter logic [15:0] HI_BASE  = 16'hFE00,
  parameter logic [15:0] MID_BASE = 16'h0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  kind,
  input  logic        byte_valid,
  input  logic [7:0]  byte_in,
  output logic [1:0]  need_cnt,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic [1:0]  op_kind,
  output logic [15:0] op_addr,
  output logic [5:0]  op_reg,
  output logic [7:0]  op_ptr,
  output logic [7:0]  op_off
);

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_t;

  st_t        st;
  logic [2:0] kind_q;
  logic [7:0] lo_q;

  logic [1:0]  nx_kind;
  logic [15:0] nx_addr;
  logic [5:0]  nx_reg;
  logic [7:0]  nx_off;

  function automatic logic [1:0] count_of(input logic [2:0] k);
    case (k)
      3'd2, 3'd3, 3'd4, 3'd5: count_of = 2'd1;
      3'd6:                   count_of = 2'd2;
      default:                count_of = 2'd0;
    endcase
  endfunction

  assign busy     = (st != S_IDLE);
  assign need_cnt = count_of(busy ? kind_q : kind);

  always_comb begin
    nx_kind = 2'd0;
    nx_addr = 16'h0000;
    nx_reg  = 6'd0;
    nx_off  = 8'h00;
    case (kind_q)
      3'd2: begin
        if (byte_in[7]) begin
          nx_kind = 2'd3;
          nx_off  = {byte_in[6], byte_in[6:0]};
        end else begin
          nx_kind = byte_in[0] ? 2'd2 : 2'd1;
          nx_reg  = byte_in[6:1];
        end
      end
      3'd3:    nx_addr = HI_BASE + {8'h00, byte_in};
      3'd5:    nx_addr = MID_BASE + {8'h00, byte_in};
      default: nx_addr = {8'h00, byte_in};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind_q  <= 3'd0;
      lo_q    <= 8'h00;
      done    <= 1'b0;
      err     <= 1'b0;
      op_kind <= 2'd0;
      op_addr <= 16'h0000;
      op_reg  <= 6'd0;
      op_ptr  <= 8'h00;
      op_off  <= 8'h00;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (count_of(kind) != 2'd0) begin
              kind_q <= kind;
              st     <= S_LO;
            end else begin
              err <= 1'b1;
            end
          end
        end
        S_LO: begin
          if (byte_valid) begin
            if (kind_q == 3'd6) begin
              lo_q <= byte_in;
              st   <= S_HI;
            end else begin
              op_kind <= nx_kind;
              op_addr <= nx_addr;
              op_reg  <= nx_reg;
              op_ptr  <= {1'b0, nx_reg, 1'b0};
              op_off  <= nx_off;
              done    <= 1'b1;
              st      <= S_IDLE;
            end
          end
        end
        default: begin
          if (byte_valid) begin
            op_kind <= 2'd0;
            op_addr <= {byte_in, lo_q};
            op_reg  <= 6'd0;
            op_ptr  <= 8'h00;
            op_off  <= 8'h00;
            done    <= 1'b1;
            st      <= S_IDLE;
          end
        end
      endcase
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(byte_valid));

  // R3
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!done && !busy));

  // R3
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(start && !busy));

  // R2
  need_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(need_cnt));

  // R4
  ptr_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_kind != 2'd0 && op_kind != 2'd3) |-> (op_ptr == {1'b0, op_reg, 1'b0}));

  // R6
  off_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_kind == 2'd3) |-> (op_off[7] == op_off[6]));

endmodule

// File: tb/mem_operand_decoder_test.sv
`timescale 1ns/1ps
module mem_operand_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic [1:0]  need_cnt;
  logic        busy, done, err;
  logic [1:0]  op_kind;
  logic [15:0] op_addr;
  logic [5:0]  op_reg;
  logic [7:0]  op_ptr;
  logic [7:0]  op_off;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mem_operand_decoder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
    .byte_valid(byte_valid), .byte_in(byte_in), .need_cnt(need_cnt),
    .busy(busy), .done(done), .err(err), .op_kind(op_kind),
    .op_addr(op_addr), .op_reg(op_reg), .op_ptr(op_ptr), .op_off(op_off)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_cnt(input logic [2:0] k);
    if (k == 3'd6) return 2'd2;
    if (k >= 3'd2 && k <= 3'd5) return 2'd1;
    return 2'd0;
  endfunction

  task automatic run_op(input logic [2:0] k, input logic [7:0] b0, input logic [7:0] b1, input bit now);
    logic [1:0]  ek;
    logic [15:0] ea;
    logic [5:0]  er;
    logic [7:0]  eo;
    int n;
    n  = exp_cnt(k);
    ek = 2'd0; ea = 16'h0; er = 6'd0; eo = 8'h0;
    case (k)
      3'd2: begin
        if (b0 >= 8'h80) begin
          ek = 2'd3;
          eo = (b0 >= 8'hC0) ? (b0 - 8'h80 + 8'h80) : (b0 - 8'h80);
        end else begin
          ek = (b0 % 2 == 1) ? 2'd2 : 2'd1;
          er = 6'(b0 / 2);
        end
      end
      3'd3: ea = 16'hFE00 + 16'(b0);
      3'd4: ea = 16'(b0);
      3'd5: ea = 16'h0100 + 16'(b0);
      3'd6: ea = 16'(b1) * 16'd256 + 16'(b0);
      default: ;
    endcase
    if (!now) @(negedge clk);
    start = 1'b1;
    kind  = k;
    #1;
    check(need_cnt == 2'(n), "R2 need_cnt idle", 32'(need_cnt), 32'(n));
    @(negedge clk);
    start = 1'b0;
    kind  = 3'd0;
    if (n == 0) begin
      check(err == 1'b1 && busy == 1'b0 && done == 1'b0, "R3 illegal kind", {err, busy, done}, 32'b100);
      @(negedge clk);
      check(err == 1'b0, "R3 err one cycle", 32'(err), 32'd0);
      return;
    end
    check(busy == 1'b1 && err == 1'b0 && done == 1'b0, "R9/R11 busy after start", {busy, err, done}, 32'b100);
    check(need_cnt == 2'(n), "R2 need_cnt held", 32'(need_cnt), 32'(n));
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1;
      byte_in    = (i == 0) ? b0 : b1;
      @(negedge clk);
    end
    byte_valid = 1'b0;
    byte_in    = 8'h00;
    check(done == 1'b1 && busy == 1'b0, "R9 done strobe", {done, busy}, 32'b10);
    check(op_kind == ek, (k == 3'd2) ? "R4/R5/R6 op_kind" : "R7/R8 op_kind", 32'(op_kind), 32'(ek));
    check(op_addr == ea, (k == 3'd6) ? "R8 op_addr" : "R7 op_addr", 32'(op_addr), 32'(ea));
    check(op_reg == er, "R4 op_reg", 32'(op_reg), 32'(er));
    check(op_ptr == 8'(er) * 8'd2, "R4 op_ptr", 32'(op_ptr), 32'(er) * 2);
    check(op_off == eo, "R6 op_off", 32'(op_off), 32'(eo));
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(done == 0 && err == 0 && busy == 0, "R1 reset strobes", {done, err, busy}, 0);
    check(op_kind == 0 && op_addr == 0 && op_reg == 0 && op_ptr == 0 && op_off == 0,
          "R1 reset fields", 32'(op_addr), 0);
    rst_n = 1'b1;

    for (int k = 0; k < 8; k++)
      for (int b = 0; b < 256; b++)
        run_op(3'(k), 8'(b), 8'(b) ^ 8'h5A, 1'b0);

    // R10 byte_valid while idle is ignored
    @(negedge clk);
    byte_valid = 1'b1; byte_in = 8'h77;
    @(negedge clk);
    @(negedge clk);
    byte_valid = 1'b0;
    check(busy == 0 && done == 0 && err == 0, "R10 idle byte ignored", {busy, done, err}, 0);
    run_op(3'd5, 8'h2C, 8'h00, 1'b0);

    // R10 start while busy is ignored
    @(negedge clk);
    start = 1'b1; kind = 3'd6;
    @(negedge clk);
    kind = 3'd0;
    #1;
    check(need_cnt == 2'd2, "R10 need_cnt ignores kind while busy", 32'(need_cnt), 2);
    @(negedge clk);
    check(err == 0 && busy == 1, "R10 start while busy ignored", {err, busy}, 2'b01);
    start = 1'b0;
    byte_valid = 1'b1; byte_in = 8'hCD;
    @(negedge clk);
    byte_in = 8'hAB;
    @(negedge clk);
    byte_valid = 1'b0;
    check(done == 1 && op_addr == 16'hABCD && op_kind == 0, "R10 R8 result after ignored start", 32'(op_addr), 32'hABCD);

    // R11 back to back: start in the done cycle
    run_op(3'd4, 8'h33, 8'h00, 1'b0);
    run_op(3'd3, 8'h81, 8'h00, 1'b1);
    run_op(3'd2, 8'hFE, 8'h00, 1'b1);
    run_op(3'd6, 8'h10, 8'hFE, 1'b1);
    run_op(3'd7, 8'h00, 8'h00, 1'b1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule